// File: doc/BRIEF.md
# Configurable Edge/Level Interrupt Controller

This block gathers up to 32 interrupt sources into two request lines for a processor, plus a wake line. A processor programs it through a small register bus. Each source has a 3-bit trigger mode that is spread over three parallel trigger registers. The mode selects rising, falling or both-edge capture, or active-high or active-low level sensing. Edge events are held in sticky latches, and software clears them by writing a 1 to that bit. A route register steers each source to one of the two request outputs. A mask register gates the request lines, and two read-only status registers show the masked, routed pending set for each output.

Every control register can be set and cleared bit by bit through its own addresses, so software never needs a read-modify-write. The wake line ignores the mask and uses a separate wake-enable register, so a sleeping core can still be woken. Each source can also take its input from a software test register instead of the pin. Each input passes through a two-flop synchroniser. The request and wake outputs and the read data are registered.

Top module: `irq_steer_ctrl`

## Requirements
- R1: After synchronous reset the registers hold these values: trigger registers 0, mask 0, wake-enable 0, route all ones, source-select all ones, test 0, both edge latch registers 0. All three outputs are low.
- R2: The bus address is {id[3:0], op[1:0]}. The ids are: 0/1/2 trigger bits t0/t1/t2, 3 source-select, 4 route, 5 wake-enable, 6 mask, 7 rising latches, 8 falling latches, 9 status0, 10 status1, 11 test. The ops are: 0 read, 1 set (1 bits set, others kept), 2 clear (1 bits cleared, others kept), 3 load. Ids 0–6 take set and clear. Ids 7–8 take clear only. Id 11 takes load only. A read with op 0 returns the value on rd_data one cycle after rd_en. A read with any other op returns 0.
- R3: A mode {t2,t1,t0}=001 captures a rising edge in the rising latch. The source stays pending until software writes 1 to that bit at id 7 op 2.
- R4: Mode 010 captures falling edges only, in the falling latch. Rising edges leave both latches unchanged.
- R5: Mode 011 captures both edges, each in its own latch, and the source is pending while either latch is set.
- R6: Mode 101 is pending while the input is high. Mode 110 is pending while the input is low. Neither mode uses a latch.
- R7: Modes 000, 100 and 111 never make a source pending and never set a latch.
- R8: req0_o is high when some pending source has its mask bit at 1 and its route bit at 1. req1_o is the same with route bit 0.
- R9: status0 reads pending & mask & route, and status1 reads pending & mask & ~route.
- R10: wake_o is high when some pending source has its wake-enable bit at 1, whatever the mask holds.
- R11: If an enabled edge is detected in the same cycle as a clear write to that latch bit, the latch stays set.
- R12: A source whose source-select bit is 1 uses its pin, and the test register has no effect on it. A source whose source-select bit is 0 uses bit n of the test register as its input.
- R13: Count from a pin change driven before clock edge k. A level-mode request output changes after edge k+2, and an edge-mode request output changes after edge k+3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 6 | Write address {id, op} |
| wr_data | input | 32 | Write data, one bit per source |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 6 | Read address {id, op} |
| rd_data | output | 32 | Registered read data |
| src_i | input | 32 | Raw asynchronous source inputs |
| req0_o | output | 1 | Request output 0 |
| req1_o | output | 1 | Request output 1 |
| wake_o | output | 1 | Wake output |

## Verification
Each trigger mode is driven with pulses one cycle wide, with long high and low holds, and with opposite-polarity edges. This separates true edge capture from level sensing and shows that each edge mode ignores the edge it is not set for. Routing and mask patterns steer the same pending source to either output or to neither, and the wake-enable path is run with the mask off to show that wake does not depend on it. A clear write is placed in the exact cycle that a new edge is detected, to show that the edge wins. The test register is driven with source-select both on and off, to show which input each source uses.

// File: rtl/irqs_pkg.sv
package irqs_pkg;
  localparam int ADDR_W = 6;
  localparam int N_CTRL = 7;

  typedef enum logic [1:0] {
    OP_READ = 2'd0,
    OP_SET  = 2'd1,
    OP_CLR  = 2'd2,
    OP_LOAD = 2'd3
  } op_e;

  typedef enum logic [3:0] {
    RID_TRIG0  = 4'd0,
    RID_TRIG1  = 4'd1,
    RID_TRIG2  = 4'd2,
    RID_SRCSEL = 4'd3,
    RID_ROUTE  = 4'd4,
    RID_WAKE   = 4'd5,
    RID_MASK   = 4'd6,
    RID_RISE   = 4'd7,
    RID_FALL   = 4'd8,
    RID_STAT0  = 4'd9,
    RID_STAT1  = 4'd10,
    RID_TEST   = 4'd11
  } rid_e;

  typedef enum logic [2:0] {
    TRIG_OFF  = 3'b000,
    TRIG_RISE = 3'b001,
    TRIG_FALL = 3'b010,
    TRIG_BOTH = 3'b011,
    TRIG_HIGH = 3'b101,
    TRIG_LOW  = 3'b110
  } trig_e;
endpackage

// File: rtl/irqs_sync.sv
// Two-flop synchroniser followed by a history register for edge detection.
module irqs_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] cur,
  output logic [W-1:0] prev
);
  logic [W-1:0] meta_q, stab_q, hist_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      stab_q <= '0;
      hist_q <= '0;
    end else begin
      meta_q <= d;
      stab_q <= meta_q;
      hist_q <= stab_q;
    end
  end

  assign cur  = stab_q;
  assign prev = hist_q;
endmodule

// File: rtl/irqs_regs.sv
// Set/clear control registers, test register and latch-clear strobes.
module irqs_regs import irqs_pkg::*; #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [3:0]   wr_id,
  input  logic [1:0]   wr_op,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] trig0,
  output logic [W-1:0] trig1,
  output logic [W-1:0] trig2,
  output logic [W-1:0] srcsel,
  output logic [W-1:0] route,
  output logic [W-1:0] wake_en,
  output logic [W-1:0] mask,
  output logic [W-1:0] test_val,
  output logic [W-1:0] rise_clr,
  output logic [W-1:0] fall_clr
);
  logic [W-1:0] ctrl_v [N_CTRL];
  logic [W-1:0] test_q;

  for (genvar g = 0; g < N_CTRL; g++) begin : g_ctrl
    localparam logic [W-1:0] RST_VAL =
      ((g == int'(RID_SRCSEL)) || (g == int'(RID_ROUTE))) ? {W{1'b1}} : {W{1'b0}};
    logic         hit;
    logic [W-1:0] q;
    assign hit = wr_en && (wr_id == 4'(g));
    always_ff @(posedge clk) begin
      if (rst) begin
        q <= RST_VAL;
      end else if (hit && (wr_op == OP_SET)) begin
        q <= q | wr_data;
      end else if (hit && (wr_op == OP_CLR)) begin
        q <= q & ~wr_data;
      end
    end
    assign ctrl_v[g] = q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      test_q <= '0;
    end else if (wr_en && (wr_id == RID_TEST) && (wr_op == OP_LOAD)) begin
      test_q <= wr_data;
    end
  end

  assign trig0    = ctrl_v[RID_TRIG0];
  assign trig1    = ctrl_v[RID_TRIG1];
  assign trig2    = ctrl_v[RID_TRIG2];
  assign srcsel   = ctrl_v[RID_SRCSEL];
  assign route    = ctrl_v[RID_ROUTE];
  assign wake_en  = ctrl_v[RID_WAKE];
  assign mask     = ctrl_v[RID_MASK];
  assign test_val = test_q;

  assign rise_clr = (wr_en && (wr_id == RID_RISE) && (wr_op == OP_CLR)) ? wr_data : '0;
  assign fall_clr = (wr_en && (wr_id == RID_FALL) && (wr_op == OP_CLR)) ? wr_data : '0;
endmodule

// File: rtl/irqs_src_cell.sv
// Per-source trigger decode, sticky edge latches and pending generation.
module irqs_src_cell import irqs_pkg::*; (
  input  logic       clk,
  input  logic       rst,
  input  logic       cur,
  input  logic       prev,
  input  logic [2:0] mode,
  input  logic       rise_clr,
  input  logic       fall_clr,
  output logic       pending,
  output logic       rise_lat,
  output logic       fall_lat
);
  logic rise_ev, fall_ev, en_r, en_f;
  logic rise_q, fall_q;

  assign rise_ev = cur & ~prev;
  assign fall_ev = ~cur & prev;
  assign en_r    = (mode == TRIG_RISE) || (mode == TRIG_BOTH);
  assign en_f    = (mode == TRIG_FALL) || (mode == TRIG_BOTH);

  // A new edge has priority over a clear in the same cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      rise_q <= (rise_q & ~rise_clr) | (en_r & rise_ev);
      fall_q <= (fall_q & ~fall_clr) | (en_f & fall_ev);
    end
  end

  always_comb begin
    unique case (mode)
      TRIG_HIGH: pending = cur;
      TRIG_LOW:  pending = ~cur;
      TRIG_RISE, TRIG_FALL, TRIG_BOTH:
                 pending = (en_r & rise_q) | (en_f & fall_q);
      default:   pending = 1'b0;
    endcase
  end

  assign rise_lat = rise_q;
  assign fall_lat = fall_q;
endmodule

// File: rtl/irq_steer_ctrl.sv
module irq_steer_ctrl import irqs_pkg::*; #(
  parameter int N_SRC = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [N_SRC-1:0]  wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [N_SRC-1:0]  rd_data,
  input  logic [N_SRC-1:0]  src_i,
  output logic              req0_o,
  output logic              req1_o,
  output logic              wake_o
);
  logic [N_SRC-1:0] trig0_q, trig1_q, trig2_q, srcsel_q, route_q, wake_q, mask_q, test_q;
  logic [N_SRC-1:0] rise_clr, fall_clr, rise_q, fall_q;
  logic [N_SRC-1:0] sel_in, s_cur, s_prev, pend, stat0, stat1;
  logic [N_SRC-1:0] rd_q, rd_mux;
  logic             req0_q, req1_q, wk_q;

  irqs_regs #(.W(N_SRC)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_id    (wr_addr[ADDR_W-1:2]),
    .wr_op    (wr_addr[1:0]),
    .wr_data  (wr_data),
    .trig0    (trig0_q),
    .trig1    (trig1_q),
    .trig2    (trig2_q),
    .srcsel   (srcsel_q),
    .route    (route_q),
    .wake_en  (wake_q),
    .mask     (mask_q),
    .test_val (test_q),
    .rise_clr (rise_clr),
    .fall_clr (fall_clr)
  );

  assign sel_in = (srcsel_q & src_i) | (~srcsel_q & test_q);

  irqs_sync #(.W(N_SRC)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .d    (sel_in),
    .cur  (s_cur),
    .prev (s_prev)
  );

  for (genvar n = 0; n < N_SRC; n++) begin : g_src
    irqs_src_cell u_cell (
      .clk      (clk),
      .rst      (rst),
      .cur      (s_cur[n]),
      .prev     (s_prev[n]),
      .mode     ({trig2_q[n], trig1_q[n], trig0_q[n]}),
      .rise_clr (rise_clr[n]),
      .fall_clr (fall_clr[n]),
      .pending  (pend[n]),
      .rise_lat (rise_q[n]),
      .fall_lat (fall_q[n])
    );
  end

  assign stat0 = pend & mask_q & route_q;
  assign stat1 = pend & mask_q & ~route_q;

  always_comb begin
    rd_mux = '0;
    if (rd_addr[1:0] == OP_READ) begin
      case (rd_addr[ADDR_W-1:2])
        RID_TRIG0:  rd_mux = trig0_q;
        RID_TRIG1:  rd_mux = trig1_q;
        RID_TRIG2:  rd_mux = trig2_q;
        RID_SRCSEL: rd_mux = srcsel_q;
        RID_ROUTE:  rd_mux = route_q;
        RID_WAKE:   rd_mux = wake_q;
        RID_MASK:   rd_mux = mask_q;
        RID_RISE:   rd_mux = rise_q;
        RID_FALL:   rd_mux = fall_q;
        RID_STAT0:  rd_mux = stat0;
        RID_STAT1:  rd_mux = stat1;
        RID_TEST:   rd_mux = test_q;
        default:    rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q   <= '0;
      req0_q <= 1'b0;
      req1_q <= 1'b0;
      wk_q   <= 1'b0;
    end else begin
      if (rd_en) rd_q <= rd_mux;
      req0_q <= |stat0;
      req1_q <= |stat1;
      wk_q   <= |(pend & wake_q);
    end
  end

  assign rd_data = rd_q;
  assign req0_o  = req0_q;
  assign req1_o  = req1_q;
  assign wake_o  = wk_q;
endmodule

// File: rtl/irqs_checker.sv
module irqs_checker import irqs_pkg::*; #(
  parameter int N = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              req0_o,
  input logic              req1_o,
  input logic              wake_o,
  input logic [N-1:0]      mask_q,
  input logic [N-1:0]      wake_q,
  input logic [N-1:0]      route_q,
  input logic [N-1:0]      trig0_q,
  input logic [N-1:0]      trig1_q,
  input logic [N-1:0]      rise_q,
  input logic [N-1:0]      fall_q
);
  AST_MASK_SILENCES_REQ: assert property (@(posedge clk) disable iff (rst)
    (mask_q == '0) |=> (!req0_o && !req1_o)); // R8

  AST_WAKE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    (wake_q == '0) |=> !wake_o); // R10

  AST_RISE_LATCH_STICKY: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && (wr_addr == {RID_RISE, OP_CLR})) |=> ((rise_q & $past(rise_q)) == $past(rise_q))); // R3

  AST_FALL_LATCH_STICKY: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && (wr_addr == {RID_FALL, OP_CLR})) |=> ((fall_q & $past(fall_q)) == $past(fall_q))); // R4

  AST_IDLE_MODES_NO_LATCH: assert property (@(posedge clk) disable iff (rst)
    (((trig0_q | trig1_q) == '0) && (rise_q == '0) && (fall_q == '0))
      |=> ((rise_q == '0) && (fall_q == '0))); // R7

  AST_REQ0_ROUTED: assert property (@(posedge clk) disable iff (rst)
    $rose(req0_o) |-> ($past(mask_q & route_q) != '0)); // R8

  AST_REQ1_ROUTED: assert property (@(posedge clk) disable iff (rst)
    $rose(req1_o) |-> ($past(mask_q & ~route_q) != '0)); // R8
endmodule

bind irq_steer_ctrl irqs_checker #(.N(N_SRC)) u_irqs_checker (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .req0_o  (req0_o),
  .req1_o  (req1_o),
  .wake_o  (wake_o),
  .mask_q  (mask_q),
  .wake_q  (wake_q),
  .route_q (route_q),
  .trig0_q (trig0_q),
  .trig1_q (trig1_q),
  .rise_q  (rise_q),
  .fall_q  (fall_q)
);

// File: tb/irq_steer_ctrl_tb_top.sv
module irq_steer_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [5:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [5:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [31:0] src_i = '0;
  logic        req0_o, req1_o, wake_o;

  int n_chk = 0;
  int n_fail = 0;
  bit cmp_on = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_steer_ctrl dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .src_i(src_i),
    .req0_o(req0_o), .req1_o(req1_o), .wake_o(wake_o)
  );

  // Behavioural reference model
  logic [31:0] m_ctrl [7];
  logic [31:0] m_test, m_s1, m_s2, m_p, m_rl, m_fl, m_rd;
  logic        m_req0, m_req1, m_wake;

  always @(posedge clk) begin
    logic [31:0] sel, pend, nrl, nfl, rclr, fclr;
    logic [2:0]  md;
    int          wid, rid;
    if (rst) begin
      for (int i = 0; i < 7; i++) m_ctrl[i] = (i == 3 || i == 4) ? 32'hFFFF_FFFF : 32'h0;
      m_test = 0; m_s1 = 0; m_s2 = 0; m_p = 0; m_rl = 0; m_fl = 0; m_rd = 0;
      m_req0 = 0; m_req1 = 0; m_wake = 0;
    end else begin
      sel  = (m_ctrl[3] & src_i) | (~m_ctrl[3] & m_test);
      wid  = int'(wr_addr[5:2]);
      rclr = (wr_en && wid == 7 && wr_addr[1:0] == 2) ? wr_data : 32'h0;
      fclr = (wr_en && wid == 8 && wr_addr[1:0] == 2) ? wr_data : 32'h0;
      for (int n = 0; n < 32; n++) begin
        md = {m_ctrl[2][n], m_ctrl[1][n], m_ctrl[0][n]};
        case (md)
          3'b101:  pend[n] = m_s2[n];
          3'b110:  pend[n] = !m_s2[n];
          3'b001:  pend[n] = m_rl[n];
          3'b010:  pend[n] = m_fl[n];
          3'b011:  pend[n] = m_rl[n] | m_fl[n];
          default: pend[n] = 1'b0;
        endcase
        nrl[n] = m_rl[n] && !rclr[n];
        nfl[n] = m_fl[n] && !fclr[n];
        if ((md == 3'b001 || md == 3'b011) && m_s2[n] && !m_p[n]) nrl[n] = 1'b1;
        if ((md == 3'b010 || md == 3'b011) && !m_s2[n] && m_p[n]) nfl[n] = 1'b1;
      end
      if (rd_en) begin
        rid = int'(rd_addr[5:2]);
        if (rd_addr[1:0] != 0) m_rd = 0;
        else if (rid < 7) m_rd = m_ctrl[rid];
        else if (rid == 7) m_rd = m_rl;
        else if (rid == 8) m_rd = m_fl;
        else if (rid == 9) m_rd = pend & m_ctrl[6] & m_ctrl[4];
        else if (rid == 10) m_rd = pend & m_ctrl[6] & ~m_ctrl[4];
        else if (rid == 11) m_rd = m_test;
        else m_rd = 0;
      end
      m_req0 = |(pend & m_ctrl[6] & m_ctrl[4]);
      m_req1 = |(pend & m_ctrl[6] & ~m_ctrl[4]);
      m_wake = |(pend & m_ctrl[5]);
      if (wr_en && wid < 7 && wr_addr[1:0] == 1) m_ctrl[wid] = m_ctrl[wid] | wr_data;
      if (wr_en && wid < 7 && wr_addr[1:0] == 2) m_ctrl[wid] = m_ctrl[wid] & ~wr_data;
      if (wr_en && wid == 11 && wr_addr[1:0] == 3) m_test = wr_data;
      m_rl = nrl; m_fl = nfl;
      m_p = m_s2; m_s2 = m_s1; m_s1 = sel;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R8 req0 vs model", {31'b0, req0_o}, {31'b0, m_req0});
      chk("R8 req1 vs model", {31'b0, req1_o}, {31'b0, m_req1});
      chk("R10 wake vs model", {31'b0, wake_o}, {31'b0, m_wake});
      chk("R2 rd_data vs model", rd_data, m_rd);
    end
  end

  task automatic wr(input logic [3:0] id, input logic [1:0] op, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = {id, op}; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] id, output logic [31:0] v);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = {id, 2'b00};
    @(negedge clk);
    rd_en = 1'b0;
    v = rd_data;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL all-requirements watchdog expired actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    cmp_on = 1'b1;

    // R1 reset values
    rd(4'd0, v);  chk("R1 trig0 reset", v, 32'h0);
    rd(4'd2, v);  chk("R1 trig2 reset", v, 32'h0);
    rd(4'd3, v);  chk("R1 srcsel reset", v, 32'hFFFF_FFFF);
    rd(4'd4, v);  chk("R1 route reset", v, 32'hFFFF_FFFF);
    rd(4'd5, v);  chk("R1 wake reset", v, 32'h0);
    rd(4'd6, v);  chk("R1 mask reset", v, 32'h0);
    rd(4'd7, v);  chk("R1 rise latch reset", v, 32'h0);
    rd(4'd11, v); chk("R1 test reset", v, 32'h0);
    chk("R1 outputs low", {29'b0, req0_o, req1_o, wake_o}, 32'h0);

    // R2 set/clear semantics on the mask register
    wr(4'd6, 2'd1, 32'h0000_00F0);
    wr(4'd6, 2'd1, 32'h0F00_0000);
    wr(4'd6, 2'd2, 32'h0000_0030);
    rd(4'd6, v); chk("R2 mask set/clear", v, 32'h0F00_00C0);
    @(negedge clk); rd_en = 1'b1; rd_addr = {4'd6, 2'd1};
    @(negedge clk); rd_en = 1'b0; chk("R2 read with non-read op", rd_data, 32'h0);
    wr(4'd6, 2'd2, 32'hFFFF_FFFF);

    // R6 / R13 high level on source 0, route to req0
    wr(4'd0, 2'd1, 32'h1); wr(4'd2, 2'd1, 32'h1); wr(4'd6, 2'd1, 32'h1);
    @(negedge clk); src_i[0] = 1'b1;
    @(negedge clk); chk("R13 level after k", {31'b0, req0_o}, 32'h0);
    @(negedge clk); chk("R13 level after k+1", {31'b0, req0_o}, 32'h0);
    @(negedge clk); chk("R13 level after k+2", {31'b0, req0_o}, 32'h1);
    src_i[0] = 1'b0;
    wait_n(4); chk("R6 high level drops with input", {31'b0, req0_o}, 32'h0);

    // R6 low level on source 1
    wr(4'd1, 2'd1, 32'h2); wr(4'd2, 2'd1, 32'h2); wr(4'd6, 2'd1, 32'h2);
    wait_n(3); rd(4'd9, v); chk("R6 low level pending", v, 32'h2);
    src_i[1] = 1'b1;
    wait_n(4); rd(4'd9, v); chk("R6 low level released", v, 32'h0);

    // R3 / R13 / R8 / R9 rising edge on source 4, routed to req1
    wr(4'd0, 2'd1, 32'h10); wr(4'd6, 2'd1, 32'h10); wr(4'd4, 2'd2, 32'h10);
    @(negedge clk); src_i[4] = 1'b1;
    @(negedge clk); src_i[4] = 1'b0; chk("R13 edge after k", {31'b0, req1_o}, 32'h0);
    @(negedge clk); chk("R13 edge after k+1", {31'b0, req1_o}, 32'h0);
    @(negedge clk); chk("R13 edge after k+2", {31'b0, req1_o}, 32'h0);
    @(negedge clk); chk("R13 edge after k+3", {31'b0, req1_o}, 32'h1);
    rd(4'd7, v); chk("R3 rise latch held after pulse", v, 32'h10);
    rd(4'd10, v); chk("R9 status1 routed source", v, 32'h10);
    rd(4'd9, v); chk("R9 status0 excludes route-0 source", v, 32'h0);
    chk("R8 req0 quiet for route-0 source", {31'b0, req0_o}, 32'h0);
    wr(4'd7, 2'd2, 32'h10);
    rd(4'd7, v); chk("R3 rise latch cleared", v, 32'h0);
    chk("R3 req1 drops after clear", {31'b0, req1_o}, 32'h0);

    // R4 falling edge on source 5
    wr(4'd1, 2'd1, 32'h20); wr(4'd6, 2'd1, 32'h20);
    src_i[5] = 1'b1; wait_n(4);
    rd(4'd8, v); chk("R4 rising edge ignored (fall)", v, 32'h0);
    rd(4'd7, v); chk("R4 rising edge ignored (rise)", v, 32'h0);
    src_i[5] = 1'b0; wait_n(4);
    rd(4'd8, v); chk("R4 falling edge latched", v, 32'h20);
    rd(4'd9, v); chk("R4 falling pending in status0", v, 32'h20);
    wr(4'd8, 2'd2, 32'h20);
    rd(4'd8, v); chk("R4 fall latch cleared", v, 32'h0);

    // R5 both edges on source 6
    wr(4'd0, 2'd1, 32'h40); wr(4'd1, 2'd1, 32'h40); wr(4'd6, 2'd1, 32'h40);
    src_i[6] = 1'b1; wait_n(4);
    rd(4'd7, v); chk("R5 rising captured", v, 32'h40);
    rd(4'd9, v); chk("R5 pending on rising", v, 32'h40);
    wr(4'd7, 2'd2, 32'h40);
    src_i[6] = 1'b0; wait_n(4);
    rd(4'd8, v); chk("R5 falling captured", v, 32'h40);
    rd(4'd7, v); chk("R5 rise latch stays clear", v, 32'h0);
    wr(4'd8, 2'd2, 32'h40);

    // R7 modes 000 / 100 / 111 on sources 7, 8, 9
    wr(4'd2, 2'd1, 32'h300); wr(4'd0, 2'd1, 32'h200); wr(4'd1, 2'd1, 32'h200);
    wr(4'd6, 2'd1, 32'h380);
    src_i[9:7] = 3'b111; wait_n(4);
    rd(4'd9, v); chk("R7 idle modes not pending high", v, 32'h0);
    src_i[9:7] = 3'b000; wait_n(4);
    rd(4'd9, v); chk("R7 idle modes not pending low", v, 32'h0);
    rd(4'd7, v); chk("R7 no rise latch", v, 32'h0);
    rd(4'd8, v); chk("R7 no fall latch", v, 32'h0);

    // R10 wake ignores mask: source 1 low-level, mask off
    wr(4'd6, 2'd2, 32'h2); wr(4'd5, 2'd1, 32'h2);
    src_i[1] = 1'b0; wait_n(4);
    chk("R10 wake with mask off", {31'b0, wake_o}, 32'h1);
    chk("R10 req0 stays low with mask off", {31'b0, req0_o}, 32'h0);
    wr(4'd5, 2'd2, 32'h2); wait_n(1);
    chk("R10 wake drops when disabled", {31'b0, wake_o}, 32'h0);
    src_i[1] = 1'b1; wait_n(4);

    // R11 edge in the same cycle as a clear on source 4
    @(negedge clk); src_i[4] = 1'b1;
    @(negedge clk);
    @(negedge clk); wr_en = 1'b1; wr_addr = {4'd7, 2'd2}; wr_data = 32'h10;
    @(negedge clk); wr_en = 1'b0;
    rd(4'd7, v); chk("R11 edge beats clear", v, 32'h10);
    src_i[4] = 1'b0;
    wr(4'd7, 2'd2, 32'h10);
    rd(4'd7, v); chk("R11 later clear works", v, 32'h0);

    // R12 test register as input source on source 10
    wr(4'd3, 2'd2, 32'h400); wr(4'd0, 2'd1, 32'h400); wr(4'd2, 2'd1, 32'h400);
    wr(4'd6, 2'd1, 32'h400);
    wr(4'd11, 2'd3, 32'h400); wait_n(4);
    rd(4'd9, v); chk("R12 test bit drives deselected source", v, 32'h400);
    wr(4'd11, 2'd3, 32'h0); wait_n(4);
    rd(4'd9, v); chk("R12 test bit low releases", v, 32'h0);
    wr(4'd3, 2'd1, 32'h400);
    wr(4'd11, 2'd3, 32'h400); wait_n(4);
    rd(4'd9, v); chk("R12 test ignored for pin source", v, 32'h0);
    wr(4'd11, 2'd3, 32'h0);
    src_i[10] = 1'b1; wait_n(4);
    rd(4'd9, v); chk("R12 pin path in normal mode", v, 32'h400);
    src_i[10] = 1'b0; wait_n(4);

    done = 1'b1;
    finish_run();
  end
endmodule